// File: doc/BRIEF.md
# Timed Heater Run Controller

This block supervises one heating run. A start strobe opens the run: the heater gets a single switch-on command and an internal down-counting timer is loaded with the programmed run length. The run closes on one of three events: the timer reaching zero after the programmed number of time-base ticks, the sampled temperature reaching the programmed limit, or a stop strobe from the operator. Any of these stops the heater with a single switch-off command. A timeout flag records whether the last run closed because its time ran out.

The run length and the temperature limit are written through plain write strobes while the controller is idle. A limit outside the open range 0 to 300 and a run length of zero are both refused, and the stored value stays as it was. A stop strobe cannot cut a run shorter than a minimum number of ticks. If it comes early, it is held and takes effect once that minimum has passed. Temperature and timeout shutdowns are never held back.

Top module: `heat_ctrl`

## Requirements
- R1: After reset the controller is idle: `running_o`, `heat_on_o`, `heat_off_o` and `timeout_o` are 0. The run length is DEF_DELAY (5) ticks and the limit is DEF_LIMIT (200).
- R2: A `start_i` seen at a clock edge while idle sets `running_o` after that edge. `heat_on_o` is 1 for exactly that one cycle. `heat_on_o` is 1 at no other time.
- R3: While running, the edge that samples the N-th `tick_i` of the run, where N is the stored run length, ends the run and sets `timeout_o`. A later accepted start clears `timeout_o`.
- R4: While running, `temp_i >= limit` (unsigned) at an edge ends the run at that edge, whatever the tick count.
- R5: A `stop_i` while running ends the run only once at least MIN_RUN (3) ticks of the run have been sampled. An earlier stop is remembered and ends the run at the first edge after the MIN_RUN-th tick. `stop_i` while idle has no effect.
- R6: A limit write is stored only if 0 < value < LIM_MAX (300). Any other value leaves the stored limit unchanged.
- R7: A run-length write of 0 is refused and leaves the stored run length unchanged. Any non-zero value is stored.
- R8: Limit and run-length writes made while running are ignored.
- R9: When several end causes coincide at one edge, the run ends once, with one switch-off pulse. The priority is stop, then temperature, then timeout, and `timeout_o` is set only when the timeout is the sole cause.
- R10: A `start_i` while running is ignored. It produces no `heat_on_o` pulse and does not reload the timer.
- R11: Every end of a run gives `heat_off_o` = 1 for exactly the one cycle in which `running_o` first reads 0. `heat_off_o` is 1 at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Run start strobe |
| stop_i | input | 1 | Operator stop strobe |
| tick_i | input | 1 | Time-base tick, one cycle per time unit |
| dly_we_i | input | 1 | Run-length write strobe |
| dly_wdata_i | input | DLY_W (8) | Run length in ticks |
| lim_we_i | input | 1 | Temperature-limit write strobe |
| lim_wdata_i | input | TEMP_W (9) | Temperature limit |
| temp_i | input | TEMP_W (9) | Sampled temperature, unsigned |
| heat_on_o | output | 1 | One-cycle heater switch-on command |
| heat_off_o | output | 1 | One-cycle heater switch-off command |
| running_o | output | 1 | Run in progress |
| timeout_o | output | 1 | Last run ended by timeout |

## Verification
The assertions check several rules on every cycle. Each switch-on pulse matches a rising edge of the running status, and each switch-off pulse matches a falling edge. The stored limit and run length always stay in their legal ranges and hold still during a run. An over-limit temperature seen while running ends the run at the next edge. The timeout flag only rises when a run ends. The exact tick on which a timeout lands, the way an early stop is held back, the priority among coinciding causes, and the refusal of bad writes all depend on counted history. Only the bench scenarios show these: a sweep over run lengths, a sweep over every limit write value, and the crafted coincidence cases.

// File: rtl/htc_pkg.sv
// Shared types for the timed heater controller.
package htc_pkg;
    // Supervisor states.
    typedef enum logic {
        SUP_IDLE = 1'b0,
        SUP_RUN  = 1'b1
    } sup_st_t;

    // Reason a run ended, in priority order.
    typedef enum logic [1:0] {
        END_NONE = 2'd0,
        END_STOP = 2'd1,
        END_HOT  = 2'd2,
        END_TMO  = 2'd3
    } end_cause_t;
endpackage

// File: rtl/htc_cfg.sv
// Configuration store: holds the run length and the temperature limit.
// Assumes idle_i is high only while the supervisor is idle. Writes made
// in any other cycle are dropped. Out-of-range values are refused.
module htc_cfg #(
    parameter int DLY_W     = 8,
    parameter int TEMP_W    = 9,
    parameter int LIM_MAX   = 300,
    parameter int DEF_DELAY = 5,
    parameter int DEF_LIMIT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_i,
    input  logic              dly_we_i,
    input  logic [DLY_W-1:0]  dly_wdata_i,
    input  logic              lim_we_i,
    input  logic [TEMP_W-1:0] lim_wdata_i,
    output logic [DLY_W-1:0]  dly_q_o,
    output logic [TEMP_W-1:0] lim_q_o
);
    localparam logic [TEMP_W:0] LIM_TOP = (TEMP_W+1)'(LIM_MAX);

    logic lim_ok;
    logic dly_ok;

    // Range checks on incoming values.
    always_comb begin
        lim_ok = (lim_wdata_i != '0) && ({1'b0, lim_wdata_i} < LIM_TOP);
        dly_ok = (dly_wdata_i != '0);
    end

    // Register update, gated by idle and the range checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q_o <= DLY_W'(DEF_DELAY);
            lim_q_o <= TEMP_W'(DEF_LIMIT);
        end else begin
            if (idle_i && dly_we_i && dly_ok) dly_q_o <= dly_wdata_i;
            if (idle_i && lim_we_i && lim_ok) lim_q_o <= lim_wdata_i;
        end
    end
endmodule

// File: rtl/htc_timer.sv
// Run timer: a down counter of remaining ticks and a saturating count of
// elapsed ticks. Assumes load_i and run_i are never high together.
module htc_timer #(
    parameter int DLY_W   = 8,
    parameter int MIN_RUN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             expire_o,
    output logic             min_ok_o
);
    localparam int EW = $clog2(MIN_RUN + 1);
    localparam logic [EW-1:0] EL_TOP = EW'(MIN_RUN);

    logic [DLY_W-1:0] rem_q;
    logic [EW-1:0]    el_q;
    logic             adv;

    // Qualified tick and outputs derived from the counters.
    always_comb begin
        adv      = run_i && tick_i;
        expire_o = adv && (rem_q == DLY_W'(1));
        min_ok_o = (el_q >= EL_TOP);
    end

    // Remaining-ticks counter: loaded at start, counted down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rem_q <= '0;
        else if (load_i)               rem_q <= delay_i;
        else if (adv && rem_q != '0)   rem_q <= rem_q - DLY_W'(1);
    end

    // Elapsed-ticks counter, saturating at the minimum run length.
    always_ff @(posedge clk) begin
        if (!rst_n)                    el_q <= '0;
        else if (load_i)               el_q <= '0;
        else if (adv && !min_ok_o)     el_q <= el_q + EW'(1);
    end
endmodule

// File: rtl/htc_heater.sv
// Heater command machine: registers one-cycle on and off commands, and
// flags an over-limit temperature while a run is active.
module htc_heater #(
    parameter int TEMP_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              run_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] limit_i,
    output logic              hot_o,
    output logic              on_pulse_o,
    output logic              off_pulse_o
);
    // Continuous over-limit comparison while running.
    always_comb hot_o = run_i && (temp_i >= limit_i);

    // Command pulses, one cycle after the supervisor's request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_pulse_o  <= 1'b0;
            off_pulse_o <= 1'b0;
        end else begin
            on_pulse_o  <= start_i;
            off_pulse_o <= stop_i;
        end
    end
endmodule

// File: rtl/heat_ctrl.sv
// Timed heater controller top: a supervisor with Idle and Running states
// drives the timer and heater machines. Every end cause goes through one
// shutdown path. Causes are ranked stop, temperature, timeout. The stop
// strobe is held until the minimum run has elapsed.
module heat_ctrl #(
    parameter int DLY_W     = 8,
    parameter int TEMP_W    = 9,
    parameter int LIM_MAX   = 300,
    parameter int MIN_RUN   = 3,
    parameter int DEF_DELAY = 5,
    parameter int DEF_LIMIT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              tick_i,
    input  logic              dly_we_i,
    input  logic [DLY_W-1:0]  dly_wdata_i,
    input  logic              lim_we_i,
    input  logic [TEMP_W-1:0] lim_wdata_i,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              heat_on_o,
    output logic              heat_off_o,
    output logic              running_o,
    output logic              timeout_o
);
    import htc_pkg::*;

    sup_st_t     st_q;
    end_cause_t  cause;
    logic        in_run;
    logic        start_acc;
    logic        stop_eff;
    logic        end_run;
    logic        stop_pend_q;
    logic        tmo_q;
    logic        expire;
    logic        min_ok;
    logic        hot;
    logic [DLY_W-1:0]  dly_q;
    logic [TEMP_W-1:0] lim_q;

    htc_cfg #(
        .DLY_W(DLY_W), .TEMP_W(TEMP_W), .LIM_MAX(LIM_MAX),
        .DEF_DELAY(DEF_DELAY), .DEF_LIMIT(DEF_LIMIT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .idle_i(st_q == SUP_IDLE),
        .dly_we_i(dly_we_i), .dly_wdata_i(dly_wdata_i),
        .lim_we_i(lim_we_i), .lim_wdata_i(lim_wdata_i),
        .dly_q_o(dly_q), .lim_q_o(lim_q)
    );

    htc_timer #(.DLY_W(DLY_W), .MIN_RUN(MIN_RUN)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(start_acc), .run_i(in_run),
        .tick_i(tick_i), .delay_i(dly_q), .expire_o(expire), .min_ok_o(min_ok)
    );

    htc_heater #(.TEMP_W(TEMP_W)) u_htr (
        .clk(clk), .rst_n(rst_n), .start_i(start_acc), .stop_i(end_run),
        .run_i(in_run), .temp_i(temp_i), .limit_i(lim_q), .hot_o(hot),
        .on_pulse_o(heat_on_o), .off_pulse_o(heat_off_o)
    );

    // Supervisor decode: start acceptance and ranked end cause.
    always_comb begin
        in_run    = (st_q == SUP_RUN);
        start_acc = (st_q == SUP_IDLE) && start_i;
        stop_eff  = in_run && (stop_i || stop_pend_q) && min_ok;
        if (stop_eff)    cause = END_STOP;
        else if (hot)    cause = END_HOT;
        else if (expire) cause = END_TMO;
        else             cause = END_NONE;
        end_run   = (cause != END_NONE);
    end

    // Supervisor state, held stop request and timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= SUP_IDLE;
            stop_pend_q <= 1'b0;
            tmo_q       <= 1'b0;
        end else if (start_acc) begin
            st_q        <= SUP_RUN;
            stop_pend_q <= 1'b0;
            tmo_q       <= 1'b0;
        end else if (end_run) begin
            st_q        <= SUP_IDLE;
            stop_pend_q <= 1'b0;
            tmo_q       <= (cause == END_TMO);
        end else if (in_run && stop_i) begin
            stop_pend_q <= 1'b1;
        end
    end

    assign running_o = in_run;
    assign timeout_o = tmo_q;
endmodule

// File: rtl/heat_ctrl_chk.sv
// Checker for heat_ctrl, attached with bind. Observes ports and the
// stored configuration only.
module heat_ctrl_chk #(
    parameter int DLY_W   = 8,
    parameter int TEMP_W  = 9,
    parameter int LIM_MAX = 300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              running_o,
    input logic              heat_on_o,
    input logic              heat_off_o,
    input logic              timeout_o,
    input logic [TEMP_W-1:0] temp_i,
    input logic [TEMP_W-1:0] lim_q,
    input logic [DLY_W-1:0]  dly_q
);
    localparam logic [TEMP_W:0] LIM_TOP = (TEMP_W+1)'(LIM_MAX);

    AST_ON_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_o) |-> heat_on_o); // R2
    AST_ON_ONLY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        heat_on_o |-> $rose(running_o)); // R10
    AST_OFF_AT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> heat_off_o); // R11
    AST_OFF_ONLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        heat_off_o |-> $fell(running_o)); // R9
    AST_HOT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && temp_i >= lim_q) |=> !running_o); // R4
    AST_TMO_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> $fell(running_o)); // R3
    AST_LIM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q != '0) && ({1'b0, lim_q} < LIM_TOP)); // R6
    AST_DLY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dly_q != '0); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |=> ($stable(lim_q) && $stable(dly_q))); // R8
endmodule

bind heat_ctrl heat_ctrl_chk #(
    .DLY_W(DLY_W), .TEMP_W(TEMP_W), .LIM_MAX(LIM_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .running_o(running_o), .heat_on_o(heat_on_o),
    .heat_off_o(heat_off_o), .timeout_o(timeout_o), .temp_i(temp_i),
    .lim_q(lim_q), .dly_q(dly_q)
);

// File: tb/sim_heat_ctrl.sv
// Bench for heat_ctrl: run-length sweep, full limit-write sweep,
// minimum-run stop, coincident causes, restart and frozen-config cases.
module sim_heat_ctrl;
    localparam int DLY_W = 8;
    localparam int TEMP_W = 9;
    localparam int LIM_MAX = 300;
    localparam int MIN_RUN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, tick_i = 0, dly_we_i = 0, lim_we_i = 0;
    logic [DLY_W-1:0]  dly_wdata_i = '0;
    logic [TEMP_W-1:0] lim_wdata_i = '0;
    logic [TEMP_W-1:0] temp_i = 9'd20;
    logic heat_on_o, heat_off_o, running_o, timeout_o;

    int errors = 0;
    int checks = 0;
    int exp_lim = 200;
    bit done = 0;

    always #5 clk = ~clk;

    heat_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .tick_i(tick_i), .dly_we_i(dly_we_i), .dly_wdata_i(dly_wdata_i),
        .lim_we_i(lim_we_i), .lim_wdata_i(lim_wdata_i), .temp_i(temp_i),
        .heat_on_o(heat_on_o), .heat_off_o(heat_off_o),
        .running_o(running_o), .timeout_o(timeout_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_start();
        start_i = 1; cyc(); start_i = 0;
    endtask

    task automatic do_stop();
        stop_i = 1; cyc(); stop_i = 0;
    endtask

    task automatic do_tick();
        tick_i = 1; cyc(); tick_i = 0;
    endtask

    task automatic wr_dly(input int v);
        dly_we_i = 1; dly_wdata_i = DLY_W'(v); cyc(); dly_we_i = 0;
    endtask

    task automatic wr_lim(input int v);
        lim_we_i = 1; lim_wdata_i = TEMP_W'(v); cyc(); lim_we_i = 0;
    endtask

    // R2 start check, then R3 timeout after d ticks and R11 single off pulse.
    task automatic run_to(input int d);
        do_start();
        chk(running_o && heat_on_o, "R2 start", int'({running_o, heat_on_o}), 3);
        chk(!timeout_o, "R3 flag cleared on start", timeout_o, 0);
        for (int k = 1; k <= d; k++) begin
            do_tick();
            if (k < d) chk(running_o, "R3 running before expiry", running_o, 1);
            else chk(!running_o && heat_off_o && timeout_o, "R3 expiry",
                     int'({running_o, heat_off_o, timeout_o}), 3);
        end
        cyc();
        chk(!heat_off_o, "R11 single off pulse", heat_off_o, 0);
    endtask

    // R4/R6: a run ends exactly when temp reaches the expected limit.
    task automatic hot_test(input int lim);
        temp_i = TEMP_W'(lim - 1);
        do_start();
        cyc(); cyc();
        chk(running_o, "R4 below limit keeps run", running_o, 1);
        temp_i = TEMP_W'(lim);
        cyc();
        chk(!running_o && heat_off_o && !timeout_o, "R6 limit stored value",
            int'({running_o, heat_off_o, timeout_o}), 2);
        temp_i = 9'd20;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk(!running_o && !heat_on_o && !heat_off_o && !timeout_o, "R1 reset outputs",
            int'({running_o, heat_on_o, heat_off_o, timeout_o}), 0);
        run_to(5);                         // R1 default run length
        hot_test(200);                     // R1 default limit

        for (int d = 1; d <= 6; d++) begin // R3 run-length sweep
            wr_dly(d);
            run_to(d);
        end
        wr_dly(0);                         // R7 zero refused, 6 kept
        run_to(6);

        for (int v = 0; v < 512; v++) begin // R6 full limit-write sweep
            wr_lim(v);
            if (v > 0 && v < LIM_MAX) exp_lim = v;
            hot_test(exp_lim);
        end

        wr_lim(200);
        wr_dly(10);
        do_start();                        // R5 early stop held
        do_stop();
        chk(running_o, "R5 early stop deferred", running_o, 1);
        for (int k = 1; k <= MIN_RUN; k++) begin
            do_tick();
            chk(running_o, "R5 held during minimum", running_o, 1);
        end
        cyc();
        chk(!running_o && heat_off_o && !timeout_o, "R5 held stop applied",
            int'({running_o, heat_off_o, timeout_o}), 2);

        do_start();                        // R5 stop after minimum acts at once
        repeat (MIN_RUN) do_tick();
        do_stop();
        chk(!running_o && heat_off_o, "R5 stop after minimum",
            int'({running_o, heat_off_o}), 2);
        cyc();
        do_stop();                         // R5 stop in idle has no effect
        chk(!running_o && !heat_off_o && !heat_on_o, "R5 idle stop ignored",
            int'({running_o, heat_off_o, heat_on_o}), 0);

        wr_dly(4);
        do_start();                        // R9 stop with final tick
        repeat (3) do_tick();
        stop_i = 1; tick_i = 1; cyc(); stop_i = 0; tick_i = 0;
        chk(!running_o && heat_off_o && !timeout_o, "R9 stop beats timeout",
            int'({running_o, heat_off_o, timeout_o}), 2);
        cyc();
        chk(!heat_off_o, "R9 single shutdown", heat_off_o, 0);

        do_start();                        // R9 temperature with final tick
        repeat (3) do_tick();
        temp_i = 9'd250; tick_i = 1; cyc(); tick_i = 0; temp_i = 9'd20;
        chk(!running_o && heat_off_o && !timeout_o, "R9 hot beats timeout",
            int'({running_o, heat_off_o, timeout_o}), 2);

        do_start();                        // R9 all three together
        repeat (3) do_tick();
        temp_i = 9'd250; tick_i = 1; stop_i = 1; cyc();
        tick_i = 0; stop_i = 0; temp_i = 9'd20;
        chk(!running_o && heat_off_o && !timeout_o, "R9 three causes",
            int'({running_o, heat_off_o, timeout_o}), 2);
        cyc();
        chk(!heat_off_o && !running_o, "R9 one pulse only", heat_off_o, 0);

        do_start();                        // R10 restart ignored
        repeat (2) do_tick();
        do_start();
        chk(running_o && !heat_on_o, "R10 no second on pulse",
            int'({running_o, heat_on_o}), 2);
        do_tick();
        chk(running_o, "R10 timer not reloaded", running_o, 1);
        do_tick();
        chk(!running_o && timeout_o, "R10 expiry on original count",
            int'({running_o, timeout_o}), 1);

        do_start();                        // R8 writes during run ignored
        temp_i = 9'd150;
        wr_lim(100);
        wr_dly(1);
        cyc();
        chk(running_o, "R8 limit write ignored", running_o, 1);
        repeat (3) do_tick();
        chk(running_o, "R8 length write ignored", running_o, 1);
        do_tick();
        chk(!running_o && timeout_o, "R8 run ends on old length",
            int'({running_o, timeout_o}), 1);
        temp_i = 9'd20;
        run_to(4);
        hot_test(200);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule